// File: doc/BRIEF.md
# Dual-Direction Tower-Field AES Byte Substitution

This block is a purely combinational byte substitution unit that serves both the forward AES substitution (used when encrypting) and the inverse substitution (used when decrypting). It holds no stored table. The unit first maps the byte into a composite field built as GF(((2^2)^2)^2). It then finds the multiplicative inverse there with a nested inverter, which reduces the work to a GF(2^4) inverse and from there to a GF(2^2) inverse. Finally it maps the result back.

All linear steps are 8x8 XOR matrices, and each of them is computed when the design is elaborated. On the forward path, the map back out of the tower is folded together with the affine transform into one matrix, and the 0x63 offset follows it. On the inverse path, the inverse affine transform and its offset are folded into the map into the tower. A single tower inverter sits between the two pairs of matrices. The select input chooses which matrix feeds the inverter and which matrix drives the result. The unit is meant to be instantiated sixteen times in a round datapath, or four times in a column-serial datapath, and the key schedule can share it.

Top module: `aes_sbox_dual`

## Requirements
- R1: With `dec_sel` = 0, `byte_out` equals the standard AES forward S-box of `byte_in`. That value is the affine step applied to the inverse of `byte_in` in GF(2^8) modulo x^8+x^4+x^3+x+1. In the affine step, result bit i is the XOR of input bits i, i+4, i+5, i+6 and i+7 (indices taken mod 8), XORed with bit i of 0x63.
- R2: With `dec_sel` = 1, `byte_out` equals the standard AES inverse S-box of `byte_in`, so that it undoes R1 for every byte.
- R3: Zero is treated as its own inverse. The forward substitution therefore maps 0x00 to 0x63, and the inverse substitution maps 0x63 to 0x00.
- R4: For all 256 bytes x, applying the inverse substitution to the forward result of x returns x.
- R5: The block has no clock and no state. `byte_out` reflects the present `byte_in` and `dec_sel` within the same time step.
- R6: The shared tower-field inverter returns a value whose tower-field product with its input is one when its input is nonzero, and returns zero for a zero input. The forward input map sends only 0x00 to the tower zero.
- R7: In each direction, the 256 input bytes produce 256 distinct output bytes.
- R8: The result depends only on the present inputs. The same byte and the same select give the same output whatever was applied before, including after the direction is switched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_in | input | 8 | Byte to substitute |
| dec_sel | input | 1 | 0 selects the forward substitution, 1 selects the inverse substitution |
| byte_out | output | 8 | Substituted byte |

## Verification
Every result of this block is due in the same time step as the input change that caused it, with zero clock cycles of latency, because no register lies between `byte_in`/`dec_sel` and `byte_out`. The bench changes the inputs on the falling clock edge and samples `byte_out` a quarter period later, well before the next rising edge. Each comparison therefore sees the settled combinational value, and no check depends on the order of events at a clock edge. The round-trip and history checks feed a sampled output straight back as the next input. They rely on this same zero-latency property.

// File: rtl/aes_sbox_tower_pkg.sv
package aes_sbox_tower_pkg;

    // Packed 8x8 GF(2) matrix: row r lives in bits [8r+7:8r]; bit c of a row
    // is the coefficient of input bit c in output bit r.
    typedef logic [63:0] xor_mat_t;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NIB_W  = BYTE_W / 2;
    localparam int unsigned PAIR_W = NIB_W / 2;

    // GF(2^2) = GF(2)[w]/(w^2+w+1); scalar for GF((2^2)^2) = GF(4)[y]/(y^2+y+PHI)
    localparam logic [PAIR_W-1:0] PHI = 2'b10;
    localparam logic [BYTE_W-1:0] AES_OFFSET = 8'h63;

    // ---------------- GF(2^2) ----------------
    function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
        logic hh;
        hh = a[1] & b[1];
        return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
    endfunction

    function automatic logic [1:0] gf4_sq(input logic [1:0] a);
        return {a[1], a[1] ^ a[0]};
    endfunction

    // In GF(4) every nonzero element satisfies a^3 = 1, so the inverse is the square.
    function automatic logic [1:0] gf4_inv(input logic [1:0] a);
        return gf4_sq(a);
    endfunction

    // ---------------- GF((2^2)^2) ----------------
    function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
        logic [1:0] p_hi, p_lo, p_mid;
        p_hi  = gf4_mul(a[3:2], b[3:2]);
        p_lo  = gf4_mul(a[1:0], b[1:0]);
        p_mid = gf4_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]);
        return {p_mid ^ p_lo, p_lo ^ gf4_mul(PHI, p_hi)};
    endfunction

    function automatic logic [3:0] gf16_inv(input logic [3:0] a);
        logic [1:0] norm, norm_inv;
        norm = gf4_mul(PHI, gf4_sq(a[3:2])) ^ gf4_mul(a[3:2], a[1:0]) ^ gf4_sq(a[1:0]);
        norm_inv = gf4_inv(norm);
        return {gf4_mul(a[3:2], norm_inv), gf4_mul(a[3:2] ^ a[1:0], norm_inv)};
    endfunction

    // Pick a lambda for which z^2+z+lambda has no root in GF(16) (irreducible).
    function automatic logic [3:0] find_lambda();
        logic [3:0] pick;
        logic       found;
        logic       hit;
        pick  = 4'h0;
        found = 1'b0;
        for (int l = 2; l < 16; l++) begin
            hit = 1'b0;
            for (int z = 0; z < 16; z++) begin
                if ((gf16_mul(z[3:0], z[3:0]) ^ z[3:0]) == l[3:0]) hit = 1'b1;
            end
            if (!hit && !found) begin
                pick  = l[3:0];
                found = 1'b1;
            end
        end
        return pick;
    endfunction

    localparam logic [NIB_W-1:0] LAMBDA = find_lambda();

    // ---------------- GF(((2^2)^2)^2) ----------------
    function automatic logic [7:0] gf256t_mul(input logic [7:0] a, input logic [7:0] b);
        logic [3:0] p_hi, p_lo, p_mid;
        p_hi  = gf16_mul(a[7:4], b[7:4]);
        p_lo  = gf16_mul(a[3:0], b[3:0]);
        p_mid = gf16_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]);
        return {p_mid ^ p_lo, p_lo ^ gf16_mul(LAMBDA, p_hi)};
    endfunction

    // Tower element that is a root of the AES polynomial x^8+x^4+x^3+x+1.
    function automatic logic [7:0] find_beta();
        logic [7:0] cand, b2, b3, b4, b8, pick;
        logic       found;
        pick  = 8'h00;
        found = 1'b0;
        for (int c = 2; c < 256; c++) begin
            cand = c[7:0];
            b2 = gf256t_mul(cand, cand);
            b3 = gf256t_mul(b2, cand);
            b4 = gf256t_mul(b2, b2);
            b8 = gf256t_mul(b4, b4);
            if (!found && ((b8 ^ b4 ^ b3 ^ cand ^ 8'h01) == 8'h00)) begin
                pick  = cand;
                found = 1'b1;
            end
        end
        return pick;
    endfunction

    // ---------------- matrix helpers ----------------
    function automatic logic [7:0] mat_vec(input xor_mat_t m, input logic [7:0] x);
        logic [7:0] y;
        for (int r = 0; r < 8; r++) y[r] = ^(m[8*r +: 8] & x);
        return y;
    endfunction

    function automatic xor_mat_t mat_mul(input xor_mat_t a, input xor_mat_t b);
        xor_mat_t   p;
        logic [7:0] col, v;
        p = '0;
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 8; k++) col[k] = b[8*k + c];
            v = mat_vec(a, col);
            for (int r = 0; r < 8; r++) p[8*r + c] = v[r];
        end
        return p;
    endfunction

    function automatic xor_mat_t mat_inv(input xor_mat_t m);
        xor_mat_t   work, acc;
        logic [7:0] tmp;
        int         piv;
        work = m;
        acc  = '0;
        for (int r = 0; r < 8; r++) acc[8*r + r] = 1'b1;
        for (int c = 0; c < 8; c++) begin
            piv = c;
            for (int r = 7; r >= c; r--) if (work[8*r + c]) piv = r;
            tmp = work[8*c +: 8]; work[8*c +: 8] = work[8*piv +: 8]; work[8*piv +: 8] = tmp;
            tmp = acc[8*c +: 8];  acc[8*c +: 8]  = acc[8*piv +: 8];  acc[8*piv +: 8]  = tmp;
            for (int r = 0; r < 8; r++) begin
                if (r != c && work[8*r + c]) begin
                    work[8*r +: 8] = work[8*r +: 8] ^ work[8*c +: 8];
                    acc[8*r +: 8]  = acc[8*r +: 8]  ^ acc[8*c +: 8];
                end
            end
        end
        return acc;
    endfunction

    // Column c of the map into the tower is beta^c.
    function automatic xor_mat_t build_to_tower(input logic [7:0] beta);
        xor_mat_t   m;
        logic [7:0] pw;
        m  = '0;
        pw = 8'h01;
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 8; r++) m[8*r + c] = pw[r];
            pw = gf256t_mul(pw, beta);
        end
        return m;
    endfunction

    function automatic xor_mat_t build_affine();
        xor_mat_t m;
        m = '0;
        for (int r = 0; r < 8; r++) begin
            m[8*r + r]           = 1'b1;
            m[8*r + ((r+4) % 8)] = 1'b1;
            m[8*r + ((r+5) % 8)] = 1'b1;
            m[8*r + ((r+6) % 8)] = 1'b1;
            m[8*r + ((r+7) % 8)] = 1'b1;
        end
        return m;
    endfunction

    // ---------------- derived constants ----------------
    localparam logic [BYTE_W-1:0] BETA     = find_beta();
    localparam xor_mat_t TO_TOWER          = build_to_tower(BETA);
    localparam xor_mat_t FROM_TOWER        = mat_inv(TO_TOWER);
    localparam xor_mat_t AFFINE            = build_affine();
    localparam xor_mat_t AFFINE_INV        = mat_inv(AFFINE);
    localparam xor_mat_t FWD_OUT_MAT       = mat_mul(AFFINE, FROM_TOWER);
    localparam xor_mat_t DEC_IN_MAT        = mat_mul(TO_TOWER, AFFINE_INV);
    localparam logic [BYTE_W-1:0] DEC_IN_OFFSET = mat_vec(DEC_IN_MAT, AES_OFFSET);

endpackage

// File: rtl/sbox_xor_map.sv
module sbox_xor_map
    import aes_sbox_tower_pkg::*;
#(
    parameter xor_mat_t          MAT    = '0,
    parameter logic [BYTE_W-1:0] OFFSET = '0
) (
    input  logic [BYTE_W-1:0] vec_i,
    output logic [BYTE_W-1:0] vec_o
);
    // one XOR tree per output bit
    for (genvar r = 0; r < BYTE_W; r++) begin : g_row
        localparam logic [BYTE_W-1:0] ROW = MAT[BYTE_W*r +: BYTE_W];
        assign vec_o[r] = (^(vec_i & ROW)) ^ OFFSET[r];
    end
endmodule

// File: rtl/sbox_gf16_inv.sv
module sbox_gf16_inv
    import aes_sbox_tower_pkg::*;
(
    input  logic [NIB_W-1:0] a_i,
    output logic [NIB_W-1:0] inv_o
);
    typedef struct packed {
        logic [PAIR_W-1:0] norm;
        logic [PAIR_W-1:0] norm_inv;
        logic [NIB_W-1:0]  res;
    } gf16_stage_t;

    gf16_stage_t st_d;

    always_comb begin
        st_d.norm = gf4_mul(PHI, gf4_sq(a_i[3:2]))
                  ^ gf4_mul(a_i[3:2], a_i[1:0])
                  ^ gf4_sq(a_i[1:0]);
        st_d.norm_inv = gf4_inv(st_d.norm);
        st_d.res = {gf4_mul(a_i[3:2], st_d.norm_inv),
                    gf4_mul(a_i[3:2] ^ a_i[1:0], st_d.norm_inv)};
    end

    assign inv_o = st_d.res;
endmodule

// File: rtl/sbox_gf256_inv.sv
module sbox_gf256_inv
    import aes_sbox_tower_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    output logic [BYTE_W-1:0] inv_o
);
    logic [NIB_W-1:0] hi, lo, norm_d, norm_inv;

    assign hi = a_i[BYTE_W-1:NIB_W];
    assign lo = a_i[NIB_W-1:0];

    always_comb begin
        norm_d = gf16_mul(LAMBDA, gf16_mul(hi, hi))
               ^ gf16_mul(hi, lo)
               ^ gf16_mul(lo, lo);
    end

    sbox_gf16_inv u_norm_inv (
        .a_i   (norm_d),
        .inv_o (norm_inv)
    );

    always_comb begin
        inv_o = {gf16_mul(hi, norm_inv), gf16_mul(hi ^ lo, norm_inv)};
    end
endmodule

// File: rtl/aes_sbox_dual.sv
module aes_sbox_dual
    import aes_sbox_tower_pkg::*;
(
    input  logic [7:0] byte_in,
    input  logic       dec_sel,
    output logic [7:0] byte_out
);
    typedef struct packed {
        logic [BYTE_W-1:0] tower_in;
    } in_sel_t;

    typedef struct packed {
        logic [BYTE_W-1:0] result;
    } out_sel_t;

    logic [BYTE_W-1:0] map_in_fwd, map_in_dec;
    logic [BYTE_W-1:0] map_out_fwd, map_out_dec;
    logic [BYTE_W-1:0] tower_in, tower_inv;
    in_sel_t           in_d;
    out_sel_t          out_d;

    // input side: plain isomorphism, or inverse affine folded into it
    sbox_xor_map #(.MAT(TO_TOWER), .OFFSET(8'h00)) u_in_fwd (
        .vec_i (byte_in), .vec_o (map_in_fwd));
    sbox_xor_map #(.MAT(DEC_IN_MAT), .OFFSET(DEC_IN_OFFSET)) u_in_dec (
        .vec_i (byte_in), .vec_o (map_in_dec));

    always_comb begin
        in_d.tower_in = dec_sel ? map_in_dec : map_in_fwd;
    end
    assign tower_in = in_d.tower_in;

    // single inverter shared by both directions
    sbox_gf256_inv u_inv (
        .a_i   (tower_in),
        .inv_o (tower_inv)
    );

    // output side: affine folded into inverse isomorphism, or plain inverse isomorphism
    sbox_xor_map #(.MAT(FWD_OUT_MAT), .OFFSET(AES_OFFSET)) u_out_fwd (
        .vec_i (tower_inv), .vec_o (map_out_fwd));
    sbox_xor_map #(.MAT(FROM_TOWER), .OFFSET(8'h00)) u_out_dec (
        .vec_i (tower_inv), .vec_o (map_out_dec));

    always_comb begin
        out_d.result = dec_sel ? map_out_dec : map_out_fwd;
    end
    assign byte_out = out_d.result;
endmodule

// File: rtl/aes_sbox_dual_chk.sv
module aes_sbox_dual_chk
    import aes_sbox_tower_pkg::*;
(
    input logic [7:0] byte_in,
    input logic       dec_sel,
    input logic [7:0] byte_out,
    input logic [7:0] tower_in,
    input logic [7:0] tower_inv
);
    always_comb begin
        if (tower_in != 8'h00) begin
            AST_INV_UNITY: assert (gf256t_mul(tower_in, tower_inv) == 8'h01); // R6
        end
        if (tower_in == 8'h00) begin
            AST_INV_ZERO: assert (tower_inv == 8'h00); // R6
        end
        if (!dec_sel) begin
            AST_FWD_MAP_NONZERO: assert ((tower_in == 8'h00) == (byte_in == 8'h00)); // R6
        end
        if (!dec_sel && byte_in == 8'h00) begin
            AST_FWD_ZERO: assert (byte_out == 8'h63); // R3
        end
        if (dec_sel && byte_in == 8'h63) begin
            AST_DEC_ZERO: assert (byte_out == 8'h00); // R3
        end
    end
endmodule

bind aes_sbox_dual aes_sbox_dual_chk u_chk (
    .byte_in   (byte_in),
    .dec_sel   (dec_sel),
    .byte_out  (byte_out),
    .tower_in  (tower_in),
    .tower_inv (tower_inv)
);

// File: tb/aes_sbox_dual_tb_top.sv
module aes_sbox_dual_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;
    localparam int N_RANDOM = 2000;

    logic       clk;
    logic       rst_n;
    logic [7:0] byte_in;
    logic       dec_sel;
    logic [7:0] byte_out;

    int  n_checks;
    int  n_fail;
    logic done;

    logic [7:0] ref_fwd [256];
    logic [7:0] ref_inv [256];

    aes_sbox_dual dut_i (
        .byte_in  (byte_in),
        .dec_sel  (dec_sel),
        .byte_out (byte_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // reference arithmetic in the plain AES field
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc, x;
        acc = 8'h00;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return acc;
    endfunction

    function automatic logic [7:0] ref_affine(input logic [7:0] a);
        logic [7:0] y;
        for (int i = 0; i < 8; i++)
            y[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8];
        return y ^ 8'h63;
    endfunction

    task automatic build_refs();
        logic [7:0] inv;
        for (int a = 0; a < 256; a++) begin
            inv = 8'h00;
            for (int b = 1; b < 256; b++)
                if (ref_mul(a[7:0], b[7:0]) == 8'h01) inv = b[7:0];
            ref_fwd[a] = ref_affine(inv);
        end
        for (int a = 0; a < 256; a++) ref_inv[ref_fwd[a]] = a[7:0];
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // drive on the falling edge, sample a quarter period later (same step, R5)
    task automatic apply(input logic [7:0] b, input logic d, output logic [7:0] res);
        @(negedge clk);
        byte_in = b;
        dec_sel = d;
        #(CLK_PERIOD/4);
        res = byte_out;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]   res;
        logic [7:0]   res2;
        logic [255:0] seen;
        logic [7:0]   rb;
        logic         rd;
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        byte_in  = 8'h00;
        dec_sel  = 1'b0;
        void'($urandom(32'h5eed_0a11));
        build_refs();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset state: zero input, forward select (R3)
        @(negedge clk);
        #(CLK_PERIOD/4);
        check8("R3 reset-state forward of 00", byte_out, 8'h63);

        // directed corners with well known table values
        apply(8'h00, 1'b0, res); check8("R3 fwd 00", res, 8'h63);
        apply(8'h63, 1'b1, res); check8("R3 inv 63", res, 8'h00);
        apply(8'h01, 1'b0, res); check8("R1 fwd 01", res, 8'h7c);
        apply(8'h53, 1'b0, res); check8("R1 fwd 53", res, 8'hed);
        apply(8'h00, 1'b1, res); check8("R2 inv 00", res, 8'h52);
        apply(8'hff, 1'b0, res); check8("R1 fwd ff", res, 8'h16);

        // exhaustive forward sweep plus permutation (R1, R7)
        seen = '0;
        for (int i = 0; i < 256; i++) begin
            apply(i[7:0], 1'b0, res);
            check8("R1 forward sweep", res, ref_fwd[i]);
            seen[res] = 1'b1;
        end
        check8("R7 forward outputs distinct", {7'd0, &seen}, 8'h01);

        // exhaustive inverse sweep plus permutation (R2, R7)
        seen = '0;
        for (int i = 0; i < 256; i++) begin
            apply(i[7:0], 1'b1, res);
            check8("R2 inverse sweep", res, ref_inv[i]);
            seen[res] = 1'b1;
        end
        check8("R7 inverse outputs distinct", {7'd0, &seen}, 8'h01);

        // round trip through the block itself (R4)
        for (int i = 0; i < 256; i++) begin
            apply(i[7:0], 1'b0, res);
            apply(res, 1'b1, res2);
            check8("R4 round trip", res2, i[7:0]);
        end

        // history independence with direction switches (R8)
        apply(8'h3c, 1'b1, res);
        apply(8'h9a, 1'b0, res);
        apply(8'hc5, 1'b1, res2);
        apply(8'h9a, 1'b0, res2);
        check8("R8 same input after other history", res2, res);
        check8("R8 value after switch", res2, ref_fwd[8'h9a]);

        // constrained random mix of bytes and directions (R1, R2, R5, R8)
        for (int n = 0; n < N_RANDOM; n++) begin
            rb = 8'($urandom_range(0, 255));
            rd = 1'($urandom_range(0, 1));
            apply(rb, rd, res);
            check8(rd ? "R2 R8 random inverse" : "R1 R8 random forward",
                   res, rd ? ref_inv[rb] : ref_fwd[rb]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule